// File: doc/BRIEF.md
# Paged Network Controller Command and Interrupt Register Block

This block is the host-visible register front end of a small network controller. The host bus has a 4-bit offset, 8-bit write and read data, and separate read and write strobes. Offset 0 always reaches the command register. The two top bits of that register choose which register page the other fifteen offsets reach. On page 0, one offset can reach one register on a read and a different register on a write. For example, offset 4 returns the transmit status on a read and loads the transmit page start on a write. That value can be read back through page 2.

The command register also sets the run state of the controller, requests a transmission, and carries a remote-DMA command code. A three-state machine handles stopping and starting. In state RUN, a stop command moves to STOPPED when no frame is in flight. If a frame is in flight, it moves to STOP_PEND instead. STOP_PEND moves to STOPPED when the frame in flight ends. STOPPED moves to RUN on a start command. Reset enters STOPPED.

An interrupt status register collects the controller's events. A mask register selects which of them drive the single interrupt line.

Top module: `nic_pagereg_top`

## Requirements
- R1: Offset 0 reaches the command register on every page. Writing it loads bits 7:6 as the page (0, 1, 2, or 3 = reserved). Reading it returns {page[1:0], dma_code[2:0], tx_req, running, stop_in_effect}. After reset it reads 0x01.
- R2: On page 0, a read of offset 4 returns the `tx_status` input. A write to offset 4 loads the transmit page start, which appears on `tx_page_start` and is read on page 2 at offset 4.
- R3: On page 1, offsets 1 to 6 are the station address bytes 0 to 5. Each is both readable and writable, and byte k drives `station_addr[8k+7:8k]`. A page-1 write to offset 4 leaves the transmit page start unchanged.
- R4: Reset enters STOPPED. A command write with bit 1 set and bit 0 clear moves STOPPED to RUN. Interrupt status bit 7 is 1 exactly while STOPPED, and `ctl_run` is 1 while not STOPPED.
- R5: A command write with bit 0 set, made in RUN while `frame_busy` is high, enters STOP_PEND. The block stays running (bit 7 clear) until `frame_busy` falls, and enters STOPPED on the next edge.
- R6: A command write with bit 2 set in RUN sets `tx_req`. The same write in STOPPED is ignored. `tx_done` clears `tx_req`.
- R7: The DMA command field holds 001 = read, 010 = write, or 011 = send. A written code 000 leaves the field unchanged. Any written code with bit 5 set stores 100 (abort), whatever the lower bits. `rdma_done` returns the field to 000.
- R8: Interrupt status bits 0 to 4 and 6 are received OK, transmitted OK, receive error, transmit error, ring overwrite, and remote DMA complete. Each is set by its event input. Writing 1 to a bit at page 0 offset 7 clears it. An event in the same cycle as the clear keeps the bit set.
- R9: Status bit 5 sets when any bit of `tally_msb` rises. A bit that stays high does not set it again after it is cleared.
- R10: Status bit 7 is read-only: writing 1 to it has no effect.
- R11: The mask is written at page 0 offset 15 and read at page 2 offset 15, with bit 7 always reading 0. `irq` is the OR of status bits 6:0 ANDed with mask bits 6:0.
- R12: On page 3, writes to offsets 1 to 15 are ignored and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; rdata is 0 when low |
| rdata | output | 8 | Read data (combinational) |
| tx_status | input | 8 | Transmit status from the MAC |
| frame_busy | input | 1 | A frame is being sent or received |
| tx_done | input | 1 | Transmission completed or aborted |
| rdma_done | input | 1 | Remote DMA finished |
| ev_rx_ok | input | 1 | Frame received without error |
| ev_tx_ok | input | 1 | Frame sent without error |
| ev_rx_err | input | 1 | Receive error |
| ev_tx_err | input | 1 | Transmit error |
| ev_ovw | input | 1 | Receive ring overwrite |
| tally_msb | input | 3 | Top bit of each tally counter |
| ctl_run | output | 1 | Controller is running (RUN or STOP_PEND) |
| tx_req | output | 1 | Transmit request |
| rdma_cmd | output | 3 | Remote DMA command code |
| tx_page_start | output | 8 | Transmit page start |
| station_addr | output | 48 | Station address bytes |
| irq | output | 1 | Interrupt request |

## Verification
The page decode is tested by writing distinct byte values through the same offset on pages 0, 1, 2 and 3. This separates a correct page decode from one that ignores the page or the access direction. The DMA code sequence writes each legal code, then 000, then two abort codes with different low bits. This tells apart "hold on 000" from "load always", and "abort overrides" from "store as written". The status tests use a lone event, an event in the same cycle as a clear, and a tally bit held high. These separate the rising-edge detect from level detect, and event-first priority from clear-first priority. The stop tests run the stop command with a frame in flight and with none, which shows whether the STOP_PEND wait is honoured.

// File: rtl/nic_reg_pkg.sv
package nic_reg_pkg;
    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_STOP_PEND = 2'd1,
        ST_STOPPED   = 2'd2
    } run_state_e;

    typedef enum logic [2:0] {
        DMA_IDLE  = 3'b000,
        DMA_READ  = 3'b001,
        DMA_WRITE = 3'b010,
        DMA_SEND  = 3'b011,
        DMA_ABORT = 3'b100
    } dma_code_e;

    localparam logic [1:0] PG0    = 2'd0;
    localparam logic [1:0] PG1    = 2'd1;
    localparam logic [1:0] PG2    = 2'd2;
    localparam logic [1:0] PG_RSV = 2'd3;

    localparam logic [3:0] OFS_CMD  = 4'd0;
    localparam logic [3:0] OFS_TX   = 4'd4;
    localparam logic [3:0] OFS_STAT = 4'd7;
    localparam logic [3:0] OFS_MASK = 4'd15;
endpackage

// File: rtl/nic_cmd_fsm.sv
module nic_cmd_fsm
    import nic_reg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_data,
    input  logic       frame_busy,
    input  logic       tx_done,
    input  logic       rdma_done,
    output run_state_e state,
    output logic       tx_req,
    output logic [2:0] rdma_cmd,
    output logic [1:0] page
);
    run_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:       if (cmd_wr && cmd_data[0])
                              state_d = frame_busy ? ST_STOP_PEND : ST_STOPPED;
            ST_STOP_PEND: if (!frame_busy) state_d = ST_STOPPED;
            ST_STOPPED:   if (cmd_wr && !cmd_data[0] && cmd_data[1]) state_d = ST_RUN;
            default:      state_d = ST_STOPPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_req   <= 1'b0;
            rdma_cmd <= DMA_IDLE;
            page     <= PG0;
        end else begin
            if (cmd_wr && cmd_data[2] && state_q == ST_RUN) tx_req <= 1'b1;
            else if (tx_done)                                tx_req <= 1'b0;

            if (cmd_wr && cmd_data[5])                rdma_cmd <= DMA_ABORT;
            else if (cmd_wr && cmd_data[4:3] != 2'b0) rdma_cmd <= {1'b0, cmd_data[4:3]};
            else if (rdma_done)                       rdma_cmd <= DMA_IDLE;

            if (cmd_wr) page <= cmd_data[7:6];
        end
    end

    assign state = state_q;

    a_r4_start_leaves_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPED && cmd_wr && cmd_data[1] && !cmd_data[0]) |=> state_q == ST_RUN);
    a_r5_stop_waits_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP_PEND && frame_busy) |=> state_q != ST_STOPPED);
    a_r6_txreq_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !cmd_wr) |=> !tx_req);
    a_r6_txreq_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPED && !tx_req) |=> !tx_req);
    a_r7_abort_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_data[5]) |=> rdma_cmd == DMA_ABORT);
endmodule

// File: rtl/nic_irq_unit.sv
module nic_irq_unit #(
    parameter int NUM_TALLY = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stat_wr,
    input  logic                 mask_wr,
    input  logic [6:0]           wbits,
    input  logic [4:0]           ev_low,
    input  logic                 ev_dma,
    input  logic [NUM_TALLY-1:0] tally_msb,
    input  logic                 stopped,
    output logic [7:0]           stat,
    output logic [6:0]           mask,
    output logic                 irq
);
    localparam int NSRC = 7;

    logic [NUM_TALLY-1:0] tally_q;
    logic                 cnt_rise;
    logic [NSRC-1:0]      ev_set;
    logic [NSRC-1:0]      stat_q;

    assign cnt_rise = |(tally_msb & ~tally_q);
    assign ev_set   = {ev_dma, cnt_rise, ev_low};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tally_q <= '0;
            mask    <= '0;
        end else begin
            tally_q <= tally_msb;
            if (mask_wr) mask <= wbits;
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   stat_q[i] <= 1'b0;
            else if (ev_set[i])           stat_q[i] <= 1'b1;
            else if (stat_wr && wbits[i]) stat_q[i] <= 1'b0;
        end

        a_r8_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
            ev_set[i] |=> stat_q[i]);
        a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_wr && wbits[i] && !ev_set[i]) |=> !stat_q[i]);
    end

    assign stat = {stopped, stat_q};
    assign irq  = |(stat_q & mask);

    a_r11_irq_quiet_without_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
endmodule

// File: rtl/nic_page_regs.sv
module nic_page_regs #(
    parameter int STA_BYTES = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sta_wr,
    input  logic [3:0]             sta_idx,
    input  logic                   tpsr_wr,
    input  logic [7:0]             wdata,
    output logic [STA_BYTES*8-1:0] station,
    output logic [7:0]             tpsr
);
    for (genvar k = 0; k < STA_BYTES; k++) begin : g_sta
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             station[k*8 +: 8] <= 8'h00;
            else if (sta_wr && sta_idx == 4'(k))    station[k*8 +: 8] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tpsr <= 8'h00;
        else if (tpsr_wr) tpsr <= wdata;
    end
endmodule

// File: rtl/nic_pagereg_top.sv
module nic_pagereg_top
    import nic_reg_pkg::*;
#(
    parameter int NUM_TALLY = 3,
    parameter int STA_BYTES = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [3:0]             addr,
    input  logic [7:0]             wdata,
    input  logic                   wr_en,
    input  logic                   rd_en,
    output logic [7:0]             rdata,
    input  logic [7:0]             tx_status,
    input  logic                   frame_busy,
    input  logic                   tx_done,
    input  logic                   rdma_done,
    input  logic                   ev_rx_ok,
    input  logic                   ev_tx_ok,
    input  logic                   ev_rx_err,
    input  logic                   ev_tx_err,
    input  logic                   ev_ovw,
    input  logic [NUM_TALLY-1:0]   tally_msb,
    output logic                   ctl_run,
    output logic                   tx_req,
    output logic [2:0]             rdma_cmd,
    output logic [7:0]             tx_page_start,
    output logic [STA_BYTES*8-1:0] station_addr,
    output logic                   irq
);
    run_state_e state;
    logic [1:0] page;
    logic [7:0] stat;
    logic [6:0] mask;
    logic [7:0] cmd_view;
    logic       wr_cmd, wr_stat, wr_mask, wr_tpsr, wr_sta;

    assign wr_cmd  = wr_en && addr == OFS_CMD;
    assign wr_stat = wr_en && page == PG0 && addr == OFS_STAT;
    assign wr_mask = wr_en && page == PG0 && addr == OFS_MASK;
    assign wr_tpsr = wr_en && page == PG0 && addr == OFS_TX;
    assign wr_sta  = wr_en && page == PG1 && addr >= 4'd1 && addr <= 4'(STA_BYTES);

    nic_cmd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_wr(wr_cmd), .cmd_data(wdata),
        .frame_busy(frame_busy), .tx_done(tx_done), .rdma_done(rdma_done),
        .state(state), .tx_req(tx_req), .rdma_cmd(rdma_cmd), .page(page)
    );

    nic_irq_unit #(.NUM_TALLY(NUM_TALLY)) u_irq (
        .clk(clk), .rst_n(rst_n), .stat_wr(wr_stat), .mask_wr(wr_mask),
        .wbits(wdata[6:0]),
        .ev_low({ev_ovw, ev_tx_err, ev_rx_err, ev_tx_ok, ev_rx_ok}),
        .ev_dma(rdma_done), .tally_msb(tally_msb),
        .stopped(state == ST_STOPPED),
        .stat(stat), .mask(mask), .irq(irq)
    );

    nic_page_regs #(.STA_BYTES(STA_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .sta_wr(wr_sta), .sta_idx(addr - 4'd1),
        .tpsr_wr(wr_tpsr), .wdata(wdata),
        .station(station_addr), .tpsr(tx_page_start)
    );

    assign ctl_run  = state != ST_STOPPED;
    assign cmd_view = {page, rdma_cmd, tx_req, state == ST_RUN, state != ST_RUN};

    always_comb begin
        rdata = 8'h00;
        if (rd_en) begin
            if (addr == OFS_CMD) begin
                rdata = cmd_view;
            end else begin
                unique case (page)
                    PG0: begin
                        if (addr == OFS_TX)   rdata = tx_status;
                        if (addr == OFS_STAT) rdata = stat;
                    end
                    PG1: begin
                        for (int k = 0; k < STA_BYTES; k++)
                            if (addr == 4'(k + 1)) rdata = station_addr[k*8 +: 8];
                    end
                    PG2: begin
                        if (addr == OFS_TX)   rdata = tx_page_start;
                        if (addr == OFS_MASK) rdata = {1'b0, mask};
                    end
                    default: rdata = 8'h00;
                endcase
            end
        end
    end

    a_r12_reserved_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (page == PG_RSV && wr_en && addr != OFS_CMD) |=>
            ($stable(mask) && $stable(tx_page_start) && $stable(station_addr) && $stable(stat[6:0])));
    a_r10_stop_bit_tracks_run: assert property (@(posedge clk) disable iff (!rst_n)
        stat[7] == !ctl_run);
endmodule

// File: tb/tb_nic_pagereg_top.sv
module tb_nic_pagereg_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  rdata;
    logic [7:0]  tx_status = 8'hC3;
    logic        frame_busy = 1'b0, tx_done = 1'b0, rdma_done = 1'b0;
    logic        ev_rx_ok = 1'b0, ev_tx_ok = 1'b0, ev_rx_err = 1'b0, ev_tx_err = 1'b0, ev_ovw = 1'b0;
    logic [2:0]  tally_msb = '0;
    logic        ctl_run, tx_req, irq;
    logic [2:0]  rdma_cmd;
    logic [7:0]  tx_page_start;
    logic [47:0] station_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    nic_pagereg_top dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
        .rdata(rdata), .tx_status(tx_status), .frame_busy(frame_busy), .tx_done(tx_done),
        .rdma_done(rdma_done), .ev_rx_ok(ev_rx_ok), .ev_tx_ok(ev_tx_ok), .ev_rx_err(ev_rx_err),
        .ev_tx_err(ev_tx_err), .ev_ovw(ev_ovw), .tally_msb(tally_msb), .ctl_run(ctl_run),
        .tx_req(tx_req), .rdma_cmd(rdma_cmd), .tx_page_start(tx_page_start),
        .station_addr(station_addr), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic cycle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(4'd0, v);  check("R1 reset cmd", v, 8'h01);
        rd(4'd7, v);  check("R4 reset status", v, 8'h80);
        check("R4 reset run", ctl_run, 1'b0);
        check("R11 reset irq", irq, 1'b0);
    endtask

    task automatic t_start_and_tx();
        logic [7:0] v;
        wr(4'd0, 8'h04);
        check("R6 tx ignored when stopped", tx_req, 1'b0);
        wr(4'd0, 8'h02);
        check("R4 running", ctl_run, 1'b1);
        rd(4'd7, v);  check("R4 status bit7 clear", v, 8'h00);
        wr(4'd0, 8'h04);
        check("R6 tx set", tx_req, 1'b1);
        rd(4'd0, v);  check("R1 cmd view", v, 8'h06);
        tx_done = 1'b1; cycle(); tx_done = 1'b0;
        check("R6 tx cleared", tx_req, 1'b0);
    endtask

    task automatic t_dma();
        wr(4'd0, 8'h08); check("R7 read code", rdma_cmd, 3'b001);
        wr(4'd0, 8'h10); check("R7 write code", rdma_cmd, 3'b010);
        wr(4'd0, 8'h18); check("R7 send code", rdma_cmd, 3'b011);
        wr(4'd0, 8'h00); check("R7 000 holds", rdma_cmd, 3'b011);
        wr(4'd0, 8'h38); check("R7 abort 111", rdma_cmd, 3'b100);
        wr(4'd0, 8'h28); check("R7 abort 101", rdma_cmd, 3'b100);
        rdma_done = 1'b1; cycle(); rdma_done = 1'b0;
        check("R7 done idles", rdma_cmd, 3'b000);
    endtask

    task automatic t_pages();
        logic [7:0] v;
        wr(4'd0, 8'h40);
        for (int k = 1; k <= 6; k++) wr(4'(k), 8'(8'h10 + k));
        check("R3 station out", station_addr, 48'h161514131211);
        rd(4'd4, v); check("R3 station rd", v, 8'h14);
        rd(4'd0, v); check("R1 page1 cmd", v, 8'h42);
        check("R3 tpsr untouched", tx_page_start, 8'h00);
        wr(4'd0, 8'h00);
        wr(4'd4, 8'h5A);
        rd(4'd4, v); check("R2 p0 rd tx_status", v, 8'hC3);
        check("R2 tpsr out", tx_page_start, 8'h5A);
        wr(4'd0, 8'h80);
        rd(4'd4, v); check("R2 p2 rd tpsr", v, 8'h5A);
        wr(4'd0, 8'h00);
    endtask

    task automatic t_status();
        logic [7:0] v;
        ev_rx_ok = 1; ev_tx_err = 1; ev_ovw = 1; cycle();
        ev_rx_ok = 0; ev_tx_err = 0; ev_ovw = 0;
        rd(4'd7, v); check("R8 events set", v, 8'h59);
        wr(4'd7, 8'h19);
        rd(4'd7, v); check("R8 w1c", v, 8'h40);
        @(negedge clk); addr = 4'd7; wdata = 8'h42; wr_en = 1; ev_tx_ok = 1;
        @(negedge clk); wr_en = 0; ev_tx_ok = 0;
        rd(4'd7, v); check("R8 event beats clear", v, 8'h02);
        ev_rx_err = 1; cycle(); ev_rx_err = 0;
        wr(4'd7, 8'h06);
        rd(4'd7, v); check("R8 clear rest", v, 8'h00);
    endtask

    task automatic t_tally();
        logic [7:0] v;
        tally_msb = 3'b010; cycle();
        rd(4'd7, v); check("R9 rise sets", v, 8'h20);
        wr(4'd7, 8'h20); cycle();
        rd(4'd7, v); check("R9 held no reset", v, 8'h00);
        tally_msb = 3'b011; cycle();
        rd(4'd7, v); check("R9 second rise", v, 8'h20);
        tally_msb = 3'b000;
        wr(4'd7, 8'h20);
    endtask

    task automatic t_mask();
        logic [7:0] v;
        wr(4'd15, 8'hFF);
        wr(4'd0, 8'h80);
        rd(4'd15, v); check("R11 mask rd", v, 8'h7F);
        wr(4'd0, 8'h00);
        ev_ovw = 1; cycle(); ev_ovw = 0;
        check("R11 irq on", irq, 1'b1);
        wr(4'd15, 8'h6F);
        check("R11 masked off", irq, 1'b0);
        wr(4'd15, 8'h10);
        check("R11 irq again", irq, 1'b1);
        wr(4'd7, 8'h10);
        check("R11 irq clears", irq, 1'b0);
    endtask

    task automatic t_stop();
        logic [7:0] v;
        frame_busy = 1'b1;
        wr(4'd0, 8'h01);
        cycle(); cycle();
        check("R5 still running", ctl_run, 1'b1);
        rd(4'd7, v); check("R5 bit7 clear pending", v, 8'h00);
        frame_busy = 1'b0; cycle();
        check("R5 stopped", ctl_run, 1'b0);
        rd(4'd7, v); check("R5 bit7 set", v, 8'h80);
        wr(4'd7, 8'h80);
        rd(4'd7, v); check("R10 bit7 read only", v, 8'h80);
        wr(4'd0, 8'h02);
        wr(4'd0, 8'h01);
        check("R5 idle stop immediate", ctl_run, 1'b0);
    endtask

    task automatic t_reserved();
        logic [7:0] v;
        wr(4'd0, 8'hC0);
        wr(4'd15, 8'h00);
        wr(4'd1, 8'hEE);
        rd(4'd7, v); check("R12 rsv read", v, 8'h00);
        rd(4'd1, v); check("R12 rsv read1", v, 8'h00);
        rd(4'd0, v); check("R1 rsv cmd", v, 8'hC1);
        wr(4'd0, 8'h80);
        rd(4'd15, v); check("R12 mask kept", v, 8'h10);
        check("R12 station kept", station_addr[7:0], 8'h11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start_and_tx();
        t_dma();
        t_pages();
        t_status();
        t_tally();
        t_mask();
        t_stop();
        t_reserved();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule